// File: doc/BRIEF.md
# Counter-Timed Power-On Reset Sequencer

This block drives a reset line for other devices on a board. It runs inside a programmable-logic device and has no reset input of its own. Its start-up state comes only from the initial values its registers load at configuration. From the first clock edge a timing counter advances by one per cycle. The board reset is held asserted while the counter runs. When the count reaches a release value, the reset is released. Once the counter's most significant bit sets, the counter halts and holds that value, and the sequence rests in a terminal stop phase.

The count also decodes a small schedule of timed side events. Each event is a registered single-bit output that is high over a configurable span of counts. Typical uses are to stagger the release of individual devices or to enable a clock buffer. Other logic can pulse a warm-restart input, which clears the counter and replays the whole sequence exactly as it ran after power-up. There is no data stream through the block, so every pin is a plain control or status signal.

Top module: `porseq_top`

## Requirements
- R1: Before any clock edge, with no reset applied, `board_rst_o` is 1, `count_o` is 0, `seq_done_o` is 0 and every bit of `event_o` is 0.
- R2: On each rising edge with `restart_i` low and `count_o[CNT_W-1]` clear, `count_o` increases by exactly one.
- R3: Once `count_o[CNT_W-1]` is set, and while `restart_i` stays low, `count_o` holds its value on every later edge.
- R4: `board_rst_o` falls on the edge at which `count_o` becomes `RELEASE_AT` (default 2048, which is when the MSB sets). That is exactly `RELEASE_AT` edges after power-up or after the restart edge. It then stays 0 until a restart.
- R5: `seq_done_o` is 1 exactly when the sequencer is in its stop phase. This is precisely when `board_rst_o` is 0.
- R6: `restart_i` is sampled on the rising edge. A single-cycle high clears `count_o` to 0 and sets `board_rst_o` to 1 after that same edge, whether the sequence is mid-run or finished. The sequence then repeats cycle for cycle, and restart takes priority over the release and the halt.
- R7: Bit i of `event_o` is 1 exactly while `EV_START[i] <= count_o < EV_END[i]`, and it changes on the same edge as `count_o`. The defaults are bit 0 over [16,1024), bit 1 over [512,2048) and bit 2 over [2000,2040).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all state changes on its rising edge |
| restart_i | input | 1 | Warm restart request, sampled synchronously |
| board_rst_o | output | 1 | Registered reset for board devices, active high |
| seq_done_o | output | 1 | High while the sequencer rests in its stop phase |
| count_o | output | CNT_W | Current value of the timing counter |
| event_o | output | NUM_EV | Registered timed event outputs, one per schedule entry |

## Verification
Every result of this block is due one rising edge after its cause. The counter step, the release of `board_rst_o`, the event windows and the effect of a restart are all visible after the edge that sampled the input, and nothing has a second register stage. The bench drives `restart_i` on falling edges. After each rising edge it advances its own model of the count, then compares every output at the next falling edge, against values derived from that count alone. A separate edge counter, kept since power-up or since the last restart, confirms that the falling edge of `board_rst_o` lands on exactly the `RELEASE_AT`-th edge.

// File: rtl/porseq_pkg.sv
package porseq_pkg;

  typedef enum logic [2:0] {
    PH_START = 3'b001,
    PH_RUN   = 3'b010,
    PH_STOP  = 3'b100
  } phase_e;

endpackage

// File: rtl/porseq_counter.sv
module porseq_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_q_o,
  output logic [CNT_W-1:0] count_d_o
);

  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q = '0;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (restart_i)       cnt_d = '0;
    else if (cnt_q[MSB]) cnt_d = cnt_q;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) cnt_q <= cnt_d;

  assign count_q_o = cnt_q;
  assign count_d_o = cnt_d;

endmodule

// File: rtl/porseq_phase.sv
module porseq_phase
  import porseq_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int RELEASE_AT = 2048
) (
  input  logic             clk_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] count_q_i,
  output logic             board_rst_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST_HELD = CNT_W'(RELEASE_AT - 1);

  phase_e phase_q = PH_START;
  phase_e phase_d;
  logic   rst_q   = 1'b1;

  always_comb begin
    phase_d = PH_START;
    if (restart_i) begin
      phase_d = PH_START;
    end else begin
      unique case (phase_q)
        PH_START, PH_RUN: phase_d = (count_q_i == LAST_HELD) ? PH_STOP : PH_RUN;
        PH_STOP:          phase_d = PH_STOP;
        default:          phase_d = PH_START;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    phase_q <= phase_d;
    rst_q   <= (phase_d != PH_STOP);
  end

  assign board_rst_o = rst_q;
  assign done_o      = (phase_q == PH_STOP);

endmodule

// File: rtl/porseq_events.sv
module porseq_events #(
  parameter int CNT_W  = 12,
  parameter int NUM_EV = 3,
  parameter logic [NUM_EV-1:0][CNT_W-1:0] EV_START = '0,
  parameter logic [NUM_EV-1:0][CNT_W-1:0] EV_END   = '0
) (
  input  logic              clk_i,
  input  logic [CNT_W-1:0]  count_d_i,
  output logic [NUM_EV-1:0] event_o
);

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    logic ev_q = 1'b0;
    logic in_win;
    assign in_win = (count_d_i >= EV_START[i]) && (count_d_i < EV_END[i]);
    always_ff @(posedge clk_i) ev_q <= in_win;
    assign event_o[i] = ev_q;
  end

endmodule

// File: rtl/porseq_top.sv
module porseq_top #(
  parameter int CNT_W      = 12,
  parameter int RELEASE_AT = 2048,
  parameter int NUM_EV     = 3,
  parameter logic [NUM_EV-1:0][CNT_W-1:0] EV_START = {12'd2000, 12'd512, 12'd16},
  parameter logic [NUM_EV-1:0][CNT_W-1:0] EV_END   = {12'd2040, 12'd2048, 12'd1024}
) (
  input  logic              clk_i,
  input  logic              restart_i,
  output logic              board_rst_o,
  output logic              seq_done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [NUM_EV-1:0] event_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  porseq_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .restart_i (restart_i),
    .count_q_o (cnt_q),
    .count_d_o (cnt_d)
  );

  porseq_phase #(.CNT_W(CNT_W), .RELEASE_AT(RELEASE_AT)) u_phase (
    .clk_i       (clk_i),
    .restart_i   (restart_i),
    .count_q_i   (cnt_q),
    .board_rst_o (board_rst_o),
    .done_o      (seq_done_o)
  );

  porseq_events #(
    .CNT_W(CNT_W), .NUM_EV(NUM_EV), .EV_START(EV_START), .EV_END(EV_END)
  ) u_events (
    .clk_i     (clk_i),
    .count_d_i (cnt_d),
    .event_o   (event_o)
  );

  assign count_o = cnt_q;

endmodule

// File: rtl/porseq_checker.sv
module porseq_checker #(
  parameter int CNT_W      = 12,
  parameter int RELEASE_AT = 2048,
  parameter int NUM_EV     = 3,
  parameter logic [NUM_EV-1:0][CNT_W-1:0] EV_START = '0,
  parameter logic [NUM_EV-1:0][CNT_W-1:0] EV_END   = '0
) (
  input logic              clk_i,
  input logic              restart_i,
  input logic              board_rst_o,
  input logic              seq_done_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [NUM_EV-1:0] event_o
);

  // Properties become live only after the first edge, once the initial
  // register values have been sampled at least once.
  logic armed = 1'b0;
  always_ff @(posedge clk_i) armed <= 1'b1;

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!armed)
    (!restart_i && !count_o[CNT_W-1]) |=> (count_o == $past(count_o) + 1'b1));

  assert_count_hold_R3: assert property (@(posedge clk_i) disable iff (!armed)
    (!restart_i && count_o[CNT_W-1]) |=> $stable(count_o));

  assert_release_point_R4: assert property (@(posedge clk_i) disable iff (!armed)
    $fell(board_rst_o) |-> (count_o == CNT_W'(RELEASE_AT)));

  assert_release_sticky_R4: assert property (@(posedge clk_i) disable iff (!armed)
    (!board_rst_o && !restart_i) |=> !board_rst_o);

  assert_done_match_R5: assert property (@(posedge clk_i) disable iff (!armed)
    seq_done_o == !board_rst_o);

  assert_restart_effect_R6: assert property (@(posedge clk_i) disable iff (!armed)
    restart_i |=> (board_rst_o && count_o == '0 && !seq_done_o));

  for (genvar i = 0; i < NUM_EV; i++) begin : g_evchk
    assert_event_window_R7: assert property (@(posedge clk_i) disable iff (!armed)
      event_o[i] == ((count_o >= EV_START[i]) && (count_o < EV_END[i])));
  end

endmodule

bind porseq_top porseq_checker #(
  .CNT_W(CNT_W), .RELEASE_AT(RELEASE_AT), .NUM_EV(NUM_EV),
  .EV_START(EV_START), .EV_END(EV_END)
) u_porseq_checker (
  .clk_i       (clk_i),
  .restart_i   (restart_i),
  .board_rst_o (board_rst_o),
  .seq_done_o  (seq_done_o),
  .count_o     (count_o),
  .event_o     (event_o)
);

// File: tb/test_porseq_top.sv
`timescale 1ns/1ps
module test_porseq_top;

  localparam int CNT_W      = 12;
  localparam int RELEASE_AT = 2048;
  localparam int NUM_EV     = 3;
  localparam logic [NUM_EV-1:0][CNT_W-1:0] EV_START = {12'd2000, 12'd512, 12'd16};
  localparam logic [NUM_EV-1:0][CNT_W-1:0] EV_END   = {12'd2040, 12'd2048, 12'd1024};

  logic              clk = 1'b0;
  logic              restart = 1'b0;
  logic              board_rst;
  logic              seq_done;
  logic [CNT_W-1:0]  count;
  logic [NUM_EV-1:0] events;

  always #2 clk = ~clk;

  porseq_top #(
    .CNT_W(CNT_W), .RELEASE_AT(RELEASE_AT), .NUM_EV(NUM_EV),
    .EV_START(EV_START), .EV_END(EV_END)
  ) i_porseq_top (
    .clk_i       (clk),
    .restart_i   (restart),
    .board_rst_o (board_rst),
    .seq_done_o  (seq_done),
    .count_o     (count),
    .event_o     (events)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;
  int  m_cnt    = 0;
  int  since    = 0;
  bit  last_rst = 1'b1;
  bit  after_restart = 1'b0;

  function automatic bit exp_rst(input int c);
    return c < RELEASE_AT;
  endfunction

  function automatic logic [NUM_EV-1:0] exp_ev(input int c);
    logic [NUM_EV-1:0] v;
    for (int i = 0; i < NUM_EV; i++)
      v[i] = (c >= int'(EV_START[i])) && (c < int'(EV_END[i]));
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // One cycle: drive restart, take the edge, update the model, compare.
  task automatic step(input bit r);
    restart = r;
    @(posedge clk);
    if (r) begin
      m_cnt = 0;
      since = 0;
    end else begin
      if (m_cnt < (1 << (CNT_W - 1))) m_cnt++;
      since++;
    end
    after_restart = r;
    @(negedge clk);
    check(after_restart ? "R6 count" : (m_cnt >= (1 << (CNT_W - 1)) ? "R3 count" : "R2 count"),
          int'(count), m_cnt);
    check(after_restart ? "R6 reset" : "R4 reset", int'(board_rst), int'(exp_rst(m_cnt)));
    check("R5 done", int'(seq_done), int'(!exp_rst(m_cnt)));
    check("R7 events", int'(events), int'(exp_ev(m_cnt)));
    if (last_rst && !board_rst)
      check("R4 release edge", since, RELEASE_AT);
    last_rst = board_rst;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step(1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check("R1 reset", int'(board_rst), 1);
    check("R1 count", int'(count), 0);
    check("R1 done", int'(seq_done), 0);
    check("R1 events", int'(events), 0);

    // Power-up sequence through release and well into the halt.
    run(2100);
    check("R3 held after halt", int'(count), 2048);

    // Restart after the run has finished.
    step(1'b1);
    run(2100);

    // Restart in the middle of a run.
    run(0);
    step(1'b1);
    run(700);
    step(1'b1);
    run(2100);

    // Two back-to-back restart pulses.
    step(1'b1);
    step(1'b1);
    run(2100);

    // Restart exactly on the edge that would otherwise release.
    step(1'b1);
    while (m_cnt != RELEASE_AT - 1) step(1'b0);
    step(1'b1);
    check("R6 restart beats release", int'(board_rst), 1);
    run(2100);

    // Random restarts.
    for (int k = 0; k < 9000; k++) step(($urandom % 400) == 0);
    run(2100);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule